// File: doc/BRIEF.md
# DDR SDRAM Burst Write Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface. It turns a single write request into one write command on the memory's command pins, followed by the matching data burst. Each request carries a bank, a starting column and a burst-length code. The row is assumed to be open already. The block presents the strobe as a rise/fall phase pair per clock, with its own output enable, and presents data and byte masks the same way. The physical double-rate output cells can then serialise each pair onto the pins.

There is no write latency. The strobe is enabled and held low in the command cycle, which gives the preamble. Each of the following clocks carries one strobe pulse and two data beats: the even beat is captured on the rising strobe edge and the odd beat on the falling edge. One clock of low strobe closes the burst as the postamble. Data is pulled from the user one clock ahead of use, through a take strobe and a column hint. The hint follows the wrapped sequential column order of the burst.

Top module: `ddrw_burst_seq`

## Requirements
- R1: While reset is held, and in every idle cycle, the command pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with bank and address at zero. In those cycles dqs_oe=0, dq_oe=0, wd_take=0 and req_ready=1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both high. The next cycle, and only that cycle, carries the write code (cs_n=0, ras_n=1, cas_n=0, we_n=0). In that cycle ddr_ba is the accepted bank, ddr_addr[COL_W-1:0] is the accepted column and the upper address bits are 0. Every other cycle is NOP.
- R3: cfg_blen is sampled at acceptance and sets N beats: code 1 gives N=2, code 2 gives N=4, code 3 gives N=8, and code 0 gives N=4. The burst then has exactly N/2 data cycles.
- R4: In the write command cycle the strobe preamble is driven: dqs_oe=1, dqs_rise=0, dqs_fall=0, and dq_oe=0.
- R5: In data cycle k (k=0..N/2-1, directly after the command cycle), dqs_oe=1, dqs_rise=1, dqs_fall=0 and dq_oe=1. In that cycle dq_rise and dm_rise carry beat 2k, and dq_fall and dm_fall carry beat 2k+1. Mask bits are active high, meaning the byte is not written.
- R6: wd_take is high in the command cycle and in every data cycle except the last. The words on wd_rise, wd_fall, wm_rise and wm_fall in a wd_take cycle appear on the dq/dm pairs in the next cycle.
- R7: In a wd_take cycle, wd_col is the column of the even beat being fetched. Beat j has the column (start rounded down to a multiple of N) + ((start mod N) + j) mod N.
- R8: The cycle after the last data cycle is the postamble: dqs_oe=1, both phases 0 and dq_oe=0. The cycle after that is idle, with dqs_oe=0.
- R9: req_ready is high only in idle cycles. A request held valid while the block is busy is ignored until req_ready returns. Its fields are sampled only at the accepting edge.
- R10: Words offered on the data inputs outside wd_take cycles never reach the pins. dq_oe stays low outside the N/2 data cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blen | input | 2 | Burst-length code, sampled at acceptance |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Starting column |
| wd_take | output | 1 | Data inputs are consumed at the next edge |
| wd_col | output | COL_W | Column of the even beat being fetched |
| wd_rise | input | DQ_W | Even beat data |
| wd_fall | input | DQ_W | Odd beat data |
| wm_rise | input | DM_W | Even beat byte mask, 1 = skip byte |
| wm_fall | input | DM_W | Odd beat byte mask, 1 = skip byte |
| ddr_cs_n | output | 1 | Chip select |
| ddr_ras_n | output | 1 | Row strobe |
| ddr_cas_n | output | 1 | Column strobe |
| ddr_we_n | output | 1 | Write enable |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| dqs_oe | output | 1 | Strobe output enable |
| dqs_rise | output | 1 | Strobe level, first half of clock |
| dqs_fall | output | 1 | Strobe level, second half of clock |
| dq_oe | output | 1 | Data output enable |
| dq_rise | output | DQ_W | Data captured on the rising strobe edge |
| dq_fall | output | DQ_W | Data captured on the falling strobe edge |
| dm_rise | output | DM_W | Mask paired with dq_rise |
| dm_fall | output | DM_W | Mask paired with dq_fall |

## Verification
The assertions assume that cfg_blen, req_bank and req_col matter only at an accepting edge, and that the user keeps the data inputs valid in every wd_take cycle without a stall. The stimulus changes the request fields and cfg_blen freely while the block is busy, and drives a fixed junk word whenever wd_take is low. In take cycles it always answers with words derived from wd_col, so the bench model can predict each beat from the column order alone.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  // Sequencer phases. The order of the phases is the order on the pins.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_POST = 2'd3
  } ddrw_state_e;

  // Width of the data-pair counter: the longest burst (8 beats) has 4 pairs.
  localparam int unsigned PAIR_W = 2;
  localparam int unsigned WIDE_W = 16;

  // log2 of the burst length for a configuration code (0 and 2 both give 4).
  function automatic logic [1:0] blen_lg(input logic [1:0] code);
    case (code)
      2'd1:    return 2'd1;
      2'd3:    return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  // Index of the last data pair for a given log2 burst length.
  function automatic logic [PAIR_W-1:0] last_pair(input logic [1:0] lg);
    logic [2:0] pairs;
    pairs = 3'd1 << (lg - 2'd1);
    return PAIR_W'(pairs - 3'd1);
  endfunction

  // Column of beat 'beat' in a sequential burst that wraps inside the
  // aligned block of 2**lg columns.
  function automatic logic [WIDE_W-1:0] wrap_col(input logic [WIDE_W-1:0] start,
                                                 input logic [WIDE_W-1:0] beat,
                                                 input logic [1:0]        lg);
    logic [WIDE_W-1:0] msk;
    msk = (WIDE_W'(1) << lg) - WIDE_W'(1);
    return (start & ~msk) | ((start + beat) & msk);
  endfunction

endpackage

// File: rtl/ddrw_ctrl.sv
module ddrw_ctrl
  import ddrw_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  parameter int unsigned BA_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_blen,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  output ddrw_state_e       state,
  output logic [BA_W-1:0]   bank_q,
  output logic [COL_W-1:0]  col_q,
  output logic              wd_take,
  output logic [COL_W-1:0]  wd_col
);

  ddrw_state_e       state_q;
  logic [PAIR_W-1:0] pair_q;
  logic [1:0]        lg_q;

  // Named internal events for the assertions.
  logic              accept;
  logic              pair_is_last;
  logic [WIDE_W-1:0] fetch_beat;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign pair_is_last = (pair_q == last_pair(lg_q));
  assign state        = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pair_q  <= '0;
      lg_q    <= 2'd2;
      bank_q  <= '0;
      col_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_CMD;
            lg_q    <= blen_lg(cfg_blen);
            bank_q  <= req_bank;
            col_q   <= req_col;
          end
        end
        ST_CMD: begin
          state_q <= ST_DATA;
          pair_q  <= '0;
        end
        ST_DATA: begin
          if (pair_is_last) state_q <= ST_POST;
          else              pair_q  <= pair_q + PAIR_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Data is pulled one clock ahead: in the command cycle for pair 0 and in
  // data cycle k for pair k+1.
  assign wd_take    = (state_q == ST_CMD) || ((state_q == ST_DATA) && !pair_is_last);
  assign fetch_beat = (state_q == ST_CMD) ? '0
                    : ((WIDE_W'(pair_q) + WIDE_W'(1)) << 1);
  assign wd_col     = COL_W'(wrap_col(WIDE_W'(col_q), fetch_beat, lg_q));

  // R2: a command cycle is always preceded by an accepting edge.
  a_r2_cmd_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD) |-> $past(accept));

  // R3: the pair counter never passes the burst's last pair.
  a_r3_pair_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (pair_q <= last_pair(lg_q)));

  // R8: the last data cycle is followed by the postamble.
  a_r8_post_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && pair_is_last) |=> (state_q == ST_POST));

  // R9: ready only comes back after the postamble.
  a_r9_ready_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> ($past(state_q) == ST_POST));

endmodule

// File: rtl/ddrw_cmd_enc.sv
module ddrw_cmd_enc
  import ddrw_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned BA_W   = 2,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ddrw_state_e       state,
  input  logic [BA_W-1:0]   bank_q,
  input  logic [COL_W-1:0]  col_q,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr
);

  logic is_write;

  assign is_write  = (state == ST_CMD);

  // Chip stays selected; only the write cycle pulls CAS and WE low.
  assign ddr_cs_n  = 1'b0;
  assign ddr_ras_n = 1'b1;
  assign ddr_cas_n = !is_write;
  assign ddr_we_n  = !is_write;
  assign ddr_ba    = is_write ? bank_q : '0;
  assign ddr_addr  = is_write ? ADDR_W'(col_q) : '0;

  // R2: a write command lasts exactly one cycle.
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cas_n |=> ddr_cas_n);

endmodule

// File: rtl/ddrw_data_path.sv
module ddrw_data_path
  import ddrw_pkg::*;
#(
  parameter int unsigned DQ_W = 32,
  parameter int unsigned DM_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ddrw_state_e     state,
  input  logic            wd_take,
  input  logic [DQ_W-1:0] wd_rise,
  input  logic [DQ_W-1:0] wd_fall,
  input  logic [DM_W-1:0] wm_rise,
  input  logic [DM_W-1:0] wm_fall,
  output logic            dqs_oe,
  output logic            dqs_rise,
  output logic            dqs_fall,
  output logic            dq_oe,
  output logic [DQ_W-1:0] dq_rise,
  output logic [DQ_W-1:0] dq_fall,
  output logic [DM_W-1:0] dm_rise,
  output logic [DM_W-1:0] dm_fall
);

  logic [DQ_W-1:0] dr_q, df_q;
  logic [DM_W-1:0] mr_q, mf_q;

  // Words only enter the pair registers in a take cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q <= '0;
      df_q <= '0;
      mr_q <= '0;
      mf_q <= '0;
    end else if (wd_take) begin
      dr_q <= wd_rise;
      df_q <= wd_fall;
      mr_q <= wm_rise;
      mf_q <= wm_fall;
    end
  end

  // Strobe phases: preamble and postamble hold it low, and each data clock
  // gives one high-then-low pulse.
  assign dqs_oe   = (state != ST_IDLE);
  assign dqs_rise = (state == ST_DATA);
  assign dqs_fall = 1'b0;
  assign dq_oe    = (state == ST_DATA);
  assign dq_rise  = dr_q;
  assign dq_fall  = df_q;
  assign dm_rise  = mr_q;
  assign dm_fall  = mf_q;

  // R6: every data cycle was loaded by a take in the cycle before.
  a_r6_data_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(wd_take));

  // R10: data stops with the strobe still enabled and low (postamble).
  a_r10_data_stops_in_post: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (dqs_oe && !dqs_rise));

endmodule

// File: rtl/ddrw_burst_seq.sv
module ddrw_burst_seq
  import ddrw_pkg::*;
#(
  parameter  int unsigned DQ_W   = 32,
  parameter  int unsigned COL_W  = 8,
  parameter  int unsigned ADDR_W = 12,
  parameter  int unsigned BA_W   = 2,
  localparam int unsigned DM_W   = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_blen,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  output logic              wd_take,
  output logic [COL_W-1:0]  wd_col,
  input  logic [DQ_W-1:0]   wd_rise,
  input  logic [DQ_W-1:0]   wd_fall,
  input  logic [DM_W-1:0]   wm_rise,
  input  logic [DM_W-1:0]   wm_fall,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              dqs_oe,
  output logic              dqs_rise,
  output logic              dqs_fall,
  output logic              dq_oe,
  output logic [DQ_W-1:0]   dq_rise,
  output logic [DQ_W-1:0]   dq_fall,
  output logic [DM_W-1:0]   dm_rise,
  output logic [DM_W-1:0]   dm_fall
);

  ddrw_state_e      state;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q;

  ddrw_ctrl #(.COL_W(COL_W), .BA_W(BA_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_blen  (cfg_blen),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_col   (req_col),
    .state     (state),
    .bank_q    (bank_q),
    .col_q     (col_q),
    .wd_take   (wd_take),
    .wd_col    (wd_col)
  );

  ddrw_cmd_enc #(.COL_W(COL_W), .BA_W(BA_W), .ADDR_W(ADDR_W)) i_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .bank_q    (bank_q),
    .col_q     (col_q),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n),
    .ddr_we_n  (ddr_we_n),
    .ddr_ba    (ddr_ba),
    .ddr_addr  (ddr_addr)
  );

  ddrw_data_path #(.DQ_W(DQ_W), .DM_W(DM_W)) i_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .wd_take  (wd_take),
    .wd_rise  (wd_rise),
    .wd_fall  (wd_fall),
    .wm_rise  (wm_rise),
    .wm_fall  (wm_fall),
    .dqs_oe   (dqs_oe),
    .dqs_rise (dqs_rise),
    .dqs_fall (dqs_fall),
    .dq_oe    (dq_oe),
    .dq_rise  (dq_rise),
    .dq_fall  (dq_fall),
    .dm_rise  (dm_rise),
    .dm_fall  (dm_fall)
  );

  // R4: the write command cycle carries the strobe preamble and no data.
  a_r4_preamble_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr_cas_n |-> (dqs_oe && !dqs_rise && !dq_oe));

  // R6: a take is always followed by a data cycle.
  a_r6_take_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    wd_take |=> dq_oe);

  // R9: no request is taken while the strobe is busy.
  a_r9_ready_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dqs_oe);

endmodule

// File: tb/test_ddrw_burst_seq.sv
module test_ddrw_burst_seq;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          ph;     // 0 idle, 1 command, 2 data, 3 postamble
    logic [3:0]  cmd;    // {cs_n, ras_n, cas_n, we_n}
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [2:0]  dqs;    // {oe, rise, fall}
    logic        dqoe;
    logic [31:0] dr, df;
    logic [3:0]  mr, mf;
    logic        take;
    logic [7:0]  col;
    logic        rdy;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_blen = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_bank = '0;
  logic [7:0]  req_col = '0;
  logic        wd_take;
  logic [7:0]  wd_col;
  logic [31:0] wd_rise = '0, wd_fall = '0;
  logic [3:0]  wm_rise = '0, wm_fall = '0;
  logic        ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
  logic [1:0]  ddr_ba;
  logic [11:0] ddr_addr;
  logic        dqs_oe, dqs_rise, dqs_fall, dq_oe;
  logic [31:0] dq_rise, dq_fall;
  logic [3:0]  dm_rise, dm_fall;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t q[$];
  logic [7:0] tag = 8'h30;

  // staged request for the next step
  logic       nv = 0;
  logic [1:0] nb = 0;
  logic [7:0] nc = 0;
  logic [1:0] ncode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddrw_burst_seq i_ddrw_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_blen(cfg_blen),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col),
    .wd_take(wd_take), .wd_col(wd_col),
    .wd_rise(wd_rise), .wd_fall(wd_fall), .wm_rise(wm_rise), .wm_fall(wm_fall),
    .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
    .ddr_ba(ddr_ba), .ddr_addr(ddr_addr),
    .dqs_oe(dqs_oe), .dqs_rise(dqs_rise), .dqs_fall(dqs_fall),
    .dq_oe(dq_oe), .dq_rise(dq_rise), .dq_fall(dq_fall),
    .dm_rise(dm_rise), .dm_fall(dm_fall)
  );

  function automatic logic [31:0] pat_a(logic [7:0] t, logic [7:0] c);
    return {t, c, 8'hA5, c ^ t};
  endfunction
  function automatic logic [31:0] pat_b(logic [7:0] t, logic [7:0] c);
    return ~pat_a(t, c) ^ 32'h0000_FF00;
  endfunction
  function automatic logic [3:0] msk_a(logic [7:0] t, logic [7:0] c);
    return 4'(c ^ t);
  endfunction
  function automatic logic [3:0] msk_b(logic [7:0] t, logic [7:0] c);
    return ~msk_a(t, c);
  endfunction

  // R7: column of beat j, written with division instead of masks.
  function automatic logic [7:0] col_of(int s, int j, int n);
    return 8'((s / n) * n + ((s % n) + j) % n);
  endfunction

  function automatic int beats_of(logic [1:0] code);
    if (code == 2'd1) return 2;
    if (code == 2'd3) return 8;
    return 4;
  endfunction

  function automatic exp_t idle_rec();
    exp_t e;
    e.ph = 0; e.cmd = 4'b0111; e.ba = '0; e.addr = '0; e.dqs = 3'b000; e.dqoe = 0;
    e.dr = '0; e.df = '0; e.mr = '0; e.mf = '0; e.take = 0; e.col = '0; e.rdy = 1;
    return e;
  endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  task automatic push_burst(logic [1:0] b, logic [7:0] c, logic [1:0] code);
    exp_t e;
    int   n;
    n = beats_of(code);
    tag = tag + 8'h11;
    e = idle_rec();
    e.ph = 1; e.cmd = 4'b0100; e.ba = b; e.addr = {4'b0, c}; e.dqs = 3'b100;
    e.take = 1; e.col = col_of(c, 0, n); e.rdy = 0;
    q.push_back(e);
    for (int k = 0; k < n / 2; k++) begin
      e = idle_rec();
      e.ph = 2; e.dqs = 3'b110; e.dqoe = 1; e.rdy = 0;
      e.dr = pat_a(tag, col_of(c, 2 * k, n)); e.df = pat_b(tag, col_of(c, 2 * k, n));
      e.mr = msk_a(tag, col_of(c, 2 * k, n)); e.mf = msk_b(tag, col_of(c, 2 * k, n));
      e.take = (k < n / 2 - 1); e.col = col_of(c, 2 * k + 2, n);
      q.push_back(e);
    end
    e = idle_rec();
    e.ph = 3; e.dqs = 3'b100; e.rdy = 0;
    q.push_back(e);
  endtask

  task automatic step();
    exp_t e;
    bit   was_idle;
    string rq_s, rq_o;
    @(negedge clk);
    if (q.size() != 0) begin e = q.pop_front(); was_idle = 0; end
    else begin e = idle_rec(); was_idle = 1; end
    case (e.ph)
      0: rq_s = "R1"; 1: rq_s = "R4"; 2: rq_s = "R5"; default: rq_s = "R8";
    endcase
    rq_o = (e.ph == 2) ? "R3" : "R10";
    chk({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == e.cmd, (e.ph == 0) ? "R1" : "R2",
        "command code", {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, e.cmd);
    chk(ddr_ba == e.ba && ddr_addr == e.addr, "R2", "bank/address",
        {ddr_ba, ddr_addr}, {e.ba, e.addr});
    chk({dqs_oe, dqs_rise, dqs_fall} == e.dqs, rq_s, "strobe phases",
        {dqs_oe, dqs_rise, dqs_fall}, e.dqs);
    chk(dq_oe == e.dqoe, rq_o, "dq_oe", dq_oe, e.dqoe);
    if (e.dqoe) begin
      chk(dq_rise == e.dr, "R5", "dq_rise", dq_rise, e.dr);
      chk(dq_fall == e.df, "R5", "dq_fall", dq_fall, e.df);
      chk(dm_rise == e.mr && dm_fall == e.mf, "R5", "dm pair",
          {dm_rise, dm_fall}, {e.mr, e.mf});
    end
    chk(wd_take == e.take, "R6", "wd_take", wd_take, e.take);
    if (e.take) chk(wd_col == e.col, "R7", "wd_col", wd_col, e.col);
    chk(req_ready == e.rdy, "R9", "req_ready", req_ready, e.rdy);
    // drive inputs for the next edge
    req_valid = nv; req_bank = nb; req_col = nc; cfg_blen = ncode;
    if (wd_take) begin
      wd_rise = pat_a(tag, wd_col); wd_fall = pat_b(tag, wd_col);
      wm_rise = msk_a(tag, wd_col); wm_fall = msk_b(tag, wd_col);
    end else begin
      // R10: junk offered outside take cycles must never appear
      wd_rise = 32'hDEAD_BEEF; wd_fall = 32'hBAD0_F00D; wm_rise = 4'hF; wm_fall = 4'hF;
    end
    if (was_idle && nv) push_burst(nb, nc, ncode);
  endtask

  task automatic do_write(logic [1:0] b, logic [7:0] c, logic [1:0] code);
    nv = 1; nb = b; nc = c; ncode = code;
    step();
    nv = 0; nb = ~b; nc = ~c; ncode = ~code;
    repeat (beats_of(code) / 2 + 3) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0111, "R1", "reset command",
        {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}, 4'b0111);
    chk(dqs_oe == 0 && dq_oe == 0, "R1", "reset enables", {dqs_oe, dq_oe}, 0);
    chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
    rst_n = 1;
    repeat (2) step();
    do_write(2'd2, 8'h13, 2'd2);   // R3 N=4, R7 wrap from offset 3
    do_write(2'd1, 8'h05, 2'd1);   // R3 N=2
    do_write(2'd3, 8'h2D, 2'd3);   // R3 N=8, wrap inside block of 8
    do_write(2'd0, 8'h40, 2'd0);   // R3 code 0 gives N=4, aligned start
    // R9: request held valid while busy; fields change under it
    nv = 1; nb = 2'd1; nc = 8'h22; ncode = 2'd1;
    step();
    nb = 2'd3; nc = 8'h3F; ncode = 2'd3;
    repeat (4) step();
    nv = 0;
    repeat (10) step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule